// File: doc/BRIEF.md
# Timed Halt Controller

This block puts a processor core into a short, timed halt and brings it back out. Software writes a halt request. On the next clock the block stops the core and gates the peripheral clocks. It then waits for a falling edge on one of four taps of a free-running prescaler. When that edge arrives, the halt ends. The core then either continues at the next instruction or begins servicing the time-base interrupt. Which of the two happens is decided by three enables.

The block also holds the operating mode, normal or slow. Software can change that mode while the block is not halted. The mode in force when the halt began is restored when the halt ends. An active-low reset ends any halt and returns the mode to normal. A watchdog interrupt that is pending on the cycle of the halt request takes precedence, and the halt is not entered.

The tap is brought into the clock domain through a two-flop synchronizer. The falling-edge detector is armed only once the halt has begun. Because of this, the first falling edge seen after entry ends the halt, even when that edge comes early in the tap period.

Top module: `timed_halt_ctrl`

## Requirements
- R1: When `halt_wr` is 1 and `wdt_irq` is 0 while the block is not halted, the outputs change on the next clock: `core_halt` becomes 1, `halt_bit` becomes 1, `periph_clk_en` becomes 0 and `mode_o` becomes 2'b10.
- R2: `tap_sel` chooses prescaler bit TAP0+TAP_STEP*`tap_sel`, where 0 is the fastest tap and 3 the slowest. The prescaler advances by one each clock from 0 after reset. The halt ends on the first falling edge of the chosen bit, seen after two synchronizing flops, once the detector is armed. The detector arms one clock after entry.
- R3: On release, if `imf`, `tb_ie` and `tb_en` are all 1 in the detection cycle, `irq_take` pulses for one cycle. The pulse falls in the cycle in which `core_halt` returns to 0.
- R4: On release, if that three-way AND is 0, `resume_seq` pulses for one cycle instead, and `irq_take` stays 0.
- R5: On release, `halt_bit` clears by itself. `mode_o` returns to the mode held before entry: 2'b00 for normal, 2'b01 for slow.
- R6: If `tb_en` is 1 on the entry cycle, `tb_latch_set` pulses for one cycle in the first halted cycle. Otherwise it stays 0.
- R7: `rst_n` low ends any halt. After reset, `core_halt` is 0, `periph_clk_en` is 1, all pulses are 0 and `mode_o` is 2'b00 (normal).
- R8: If `wdt_irq` is 1 in the cycle of `halt_wr`, the halt is not entered and `tb_latch_set` does not pulse.
- R9: A halt never lasts more than 2^(PW)+4 clocks, where PW is the prescaler width.
- R10: `mode_wr` and `halt_wr` have no effect while halted. If both are written in the same cycle, the halt request wins and the mode write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_wr | input | 1 | Write of 1 to the halt request bit |
| mode_wr | input | 1 | Write strobe for the operating mode |
| mode_slow | input | 1 | Mode value written: 1 for slow, 0 for normal |
| imf | input | 1 | Master interrupt enable |
| tb_ie | input | 1 | Time-base interrupt enable |
| tb_en | input | 1 | Time-base enable |
| tap_sel | input | SEL_W | Prescaler tap select, 0 is fastest |
| wdt_irq | input | 1 | Pending watchdog interrupt |
| core_halt | output | 1 | Holds the core halted |
| periph_clk_en | output | 1 | Peripheral clock enable, 0 during halt |
| halt_bit | output | 1 | Read-back of the halt request bit |
| mode_o | output | 2 | 00 normal, 01 slow, 10 halted |
| tb_latch_set | output | 1 | Pulse that sets the time-base interrupt latch |
| irq_take | output | 1 | Pulse that starts time-base interrupt service on wake |
| resume_seq | output | 1 | Pulse that resumes at the next instruction on wake |

## Verification
The bench enters the halt on every tap, in both modes, and under each way the three-way AND can be 0. Two faults are the target here. A design that decoded the AND wrongly would take an interrupt where execution should simply continue. A design that lost the saved mode would wake a slow core in normal mode.

The bench enters on a tap that is already high. An unarmed or stale edge detector would then release the halt at once, or one synchronizer stage out of step.

Three further cases are covered. A halt request is made with a watchdog interrupt pending; a design that ignored the interrupt would halt. Writes are made during the halt; a design that let them through would change the mode or the halt state. Reset is applied in the middle of a halt; a design that kept the saved mode through reset would come back slow.

// File: rtl/timed_halt_ctrl.sv
module timed_halt_ctrl #(
  parameter int TAP0     = 2,
  parameter int TAP_STEP = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_wr,
  input  logic             mode_wr,
  input  logic             mode_slow,
  input  logic             imf,
  input  logic             tb_ie,
  input  logic             tb_en,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             wdt_irq,
  output logic             core_halt,
  output logic             periph_clk_en,
  output logic             halt_bit,
  output logic [1:0]       mode_o,
  output logic             tb_latch_set,
  output logic             irq_take,
  output logic             resume_seq
);
  localparam int NTAP = 1 << SEL_W;
  localparam int PW   = TAP0 + TAP_STEP*(NTAP-1) + 1;

  logic [PW-1:0]   presc;
  logic [NTAP-1:0] taps;
  logic [2:0]      sync;
  logic            halted, armed, slow, prev_slow, fall, wake_irq;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign taps[i] = presc[TAP0 + TAP_STEP*i];
  end

  assign fall          = armed & sync[2] & ~sync[1];
  assign wake_irq      = imf & tb_ie & tb_en;
  assign core_halt     = halted;
  assign halt_bit      = halted;
  assign periph_clk_en = ~halted;
  assign mode_o        = halted ? 2'b10 : {1'b0, slow};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc        <= '0;
      sync         <= '0;
      halted       <= 1'b0;
      armed        <= 1'b0;
      slow         <= 1'b0;
      prev_slow    <= 1'b0;
      tb_latch_set <= 1'b0;
      irq_take     <= 1'b0;
      resume_seq   <= 1'b0;
    end else begin
      presc        <= presc + 1'b1;
      sync         <= {sync[1:0], taps[tap_sel]};
      armed        <= halted & ~fall;
      tb_latch_set <= 1'b0;
      irq_take     <= 1'b0;
      resume_seq   <= 1'b0;
      if (halted) begin
        if (fall) begin
          halted     <= 1'b0;
          slow       <= prev_slow;
          irq_take   <= wake_irq;
          resume_seq <= ~wake_irq;
        end
      end else if (halt_wr) begin
        if (!wdt_irq) begin
          halted       <= 1'b1;
          prev_slow    <= slow;
          tb_latch_set <= tb_en;
        end
      end else if (mode_wr) begin
        slow <= mode_slow;
      end
    end
  end
endmodule

module timed_halt_ctrl_chk #(
  parameter int TAP0     = 2,
  parameter int TAP_STEP = 2,
  parameter int SEL_W    = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_wr,
  input logic       mode_wr,
  input logic       wdt_irq,
  input logic       core_halt,
  input logic       periph_clk_en,
  input logic [1:0] mode_o,
  input logic       tb_latch_set,
  input logic       irq_take,
  input logic       resume_seq
);
  localparam int PW    = TAP0 + TAP_STEP*((1 << SEL_W)-1) + 1;
  localparam int LIMIT = (1 << PW) + 4;
  int unsigned dur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dur <= 0;
    else dur <= core_halt ? dur + 1 : 0;

  p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && halt_wr && !wdt_irq) |=> (core_halt && !periph_clk_en && mode_o == 2'b10));
  p_wdt_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && halt_wr && wdt_irq) |=> (!core_halt && !tb_latch_set));
  p_wake_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_halt) |-> (irq_take ^ resume_seq));
  p_no_stray_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take || resume_seq) |-> $fell(core_halt));
  p_latch_at_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tb_latch_set |-> $rose(core_halt));
  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt && mode_wr) |=> (core_halt || irq_take || resume_seq));
  p_short_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dur <= LIMIT);
endmodule

bind timed_halt_ctrl timed_halt_ctrl_chk #(.TAP0(TAP0), .TAP_STEP(TAP_STEP), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_wr(halt_wr), .mode_wr(mode_wr), .wdt_irq(wdt_irq),
  .core_halt(core_halt), .periph_clk_en(periph_clk_en), .mode_o(mode_o),
  .tb_latch_set(tb_latch_set), .irq_take(irq_take), .resume_seq(resume_seq));

// File: tb/timed_halt_ctrl_test.sv
module timed_halt_ctrl_test;
  localparam int TAP0 = 2, TAP_STEP = 2, SEL_W = 2;
  localparam int PW = TAP0 + TAP_STEP*3 + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_wr = 0, mode_wr = 0, mode_slow = 0, imf = 0, tb_ie = 0, tb_en = 0, wdt_irq = 0;
  logic [SEL_W-1:0] tap_sel = '0;
  logic core_halt, periph_clk_en, halt_bit, tb_latch_set, irq_take, resume_seq;
  logic [1:0] mode_o;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  timed_halt_ctrl #(.TAP0(TAP0), .TAP_STEP(TAP_STEP), .SEL_W(SEL_W)) uut (
    .clk(clk), .rst_n(rst_n), .halt_wr(halt_wr), .mode_wr(mode_wr), .mode_slow(mode_slow),
    .imf(imf), .tb_ie(tb_ie), .tb_en(tb_en), .tap_sel(tap_sel), .wdt_irq(wdt_irq),
    .core_halt(core_halt), .periph_clk_en(periph_clk_en), .halt_bit(halt_bit), .mode_o(mode_o),
    .tb_latch_set(tb_latch_set), .irq_take(irq_take), .resume_seq(resume_seq));

  // behavioural reference
  int  m_cnt;
  bit  m_hist[$];
  bit  m_halt, m_arm, m_slow, m_prev, m_latch, m_irq, m_seq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hist = '{0, 0, 0};
      m_halt = 0; m_arm = 0; m_slow = 0; m_prev = 0; m_latch = 0; m_irq = 0; m_seq = 0;
    end else begin
      bit fell, tapv;
      fell = m_arm && m_hist[2] && !m_hist[1];
      tapv = ((m_cnt >> (TAP0 + TAP_STEP*int'(tap_sel))) & 1) != 0;
      m_arm = m_halt && !fell;
      m_latch = 0; m_irq = 0; m_seq = 0;
      if (m_halt) begin
        if (fell) begin
          m_halt = 0; m_slow = m_prev;
          if (imf && tb_ie && tb_en) m_irq = 1; else m_seq = 1;
        end
      end else if (halt_wr) begin
        if (!wdt_irq) begin m_halt = 1; m_prev = m_slow; m_latch = tb_en; end
      end else if (mode_wr) m_slow = mode_slow;
      m_hist.push_front(tapv);
      void'(m_hist.pop_back());
      m_cnt = (m_cnt + 1) % (1 << PW);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R1 core_halt", core_halt, m_halt);
    check("R1 periph_clk_en", periph_clk_en, !m_halt);
    check("R5 halt_bit", halt_bit, m_halt);
    check("R5 mode_o", mode_o, m_halt ? 2 : (m_slow ? 1 : 0));
    check("R6 tb_latch_set", tb_latch_set, m_latch);
    check("R3 irq_take", irq_take, m_irq);
    check("R4 resume_seq", resume_seq, m_seq);
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input bit s);
    mode_wr = 1; mode_slow = s; tick(); mode_wr = 0;
  endtask

  // enter, wait for release, check span and outcome
  task automatic run_halt(input int sel, input bit i, input bit e, input bit t, input bit slow_exp);
    int dur = 0;
    tap_sel = sel[SEL_W-1:0]; imf = i; tb_ie = e; tb_en = t;
    halt_wr = 1; tick(); halt_wr = 0;
    check("R1 entered", core_halt, 1);
    check("R6 latch at entry", tb_latch_set, t);
    while (core_halt && dur < 2000) begin tick(); dur++; end
    check("R9 halt span bound", (dur <= (2 << (TAP0 + TAP_STEP*sel)) + 4) ? 1 : 0, 1);
    check("R2 released by tap edge", core_halt, 0);
    check("R3 irq on wake", irq_take, i & e & t);
    check("R4 resume on wake", resume_seq, !(i & e & t));
    check("R5 mode restored", mode_o, slow_exp ? 1 : 0);
    check("R5 halt bit cleared", halt_bit, 0);
    tick(3);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    check("R7 reset core_halt", core_halt, 0);
    check("R7 reset mode", mode_o, 0);
    check("R7 reset clk en", periph_clk_en, 1);
    rst_n = 1; tick(2);

    for (int s = 0; s < 4; s++) run_halt(s, 1, 1, 1, 0);
    run_halt(1, 0, 1, 1, 0);
    run_halt(2, 1, 0, 1, 0);
    run_halt(0, 1, 1, 0, 0);
    set_mode(1);
    check("R5 slow mode set", mode_o, 1);
    run_halt(3, 1, 1, 1, 1);
    run_halt(0, 0, 0, 0, 1);
    tick(7);
    run_halt(1, 1, 1, 1, 1);

    // R8: pending watchdog blocks entry
    wdt_irq = 1; halt_wr = 1; tb_en = 1; tick(); halt_wr = 0; wdt_irq = 0;
    check("R8 not entered", core_halt, 0);
    check("R8 no latch pulse", tb_latch_set, 0);
    tick(2);

    // R10: writes while halted ignored; same-cycle halt wins over mode write
    tap_sel = 3; imf = 1; tb_ie = 1; tb_en = 1;
    halt_wr = 1; mode_wr = 1; mode_slow = 0; tick(); halt_wr = 0; mode_wr = 0;
    check("R10 halt wins", core_halt, 1);
    mode_wr = 1; mode_slow = 0; halt_wr = 1; tick(); mode_wr = 0; halt_wr = 0;
    check("R10 still halted", core_halt, 1);
    while (core_halt) tick();
    check("R10 mode kept slow", mode_o, 1);
    tick(3);

    // R7: reset during halt
    tap_sel = 3; halt_wr = 1; tick(); halt_wr = 0; tick(5);
    check("R7 halted before reset", core_halt, 1);
    rst_n = 0; tick();
    check("R7 reset ends halt", core_halt, 0);
    rst_n = 1; tick();
    check("R7 normal after reset", mode_o, 0);
    run_halt(2, 0, 1, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule